// File: doc/BRIEF.md
# BCD Calendar Clock Register File

This block keeps wall-clock time and calendar date in eight packed-BCD byte registers: hundredths, seconds, minutes, hours, day of week, date, month and two-digit year. A single-cycle enable, pulsed at 100 Hz by the surrounding logic, advances the hundredths counter. Carries ripple up the chain through seconds, minutes and hours, and on to the day-of-week and calendar fields. The month length follows the month and year, with leap-year handling for February.

A serial access front end talks to the block through a byte-wide port. To set the clock, it writes bytes into a staging set, one register index at a time, and then pulses a commit strobe that replaces all eight live registers in one cycle. To read the clock, it pulses a snapshot strobe that freezes all eight live registers in one cycle, and then reads the frozen bytes by index. The hours register carries its own 12/24-hour format bit. The day-of-week register also holds an oscillator-halt bit and a reset-pin-ignore bit, and both are brought out as outputs.

Top module: `rtc_bcd_regfile`

## Requirements
- R1: After reset the eight registers (index 0..7) read 00, 00, 00, 00, 31, 01, 01, 00 (hex). In register 4, bit 5 (halt) and bit 4 (reset-pin ignore) are both 1, so `halted_o` and `rstpin_ignore_o` are 1.
- R2: Register 0 holds tenths in bits 7..4 and hundredths in bits 3..0. Each counted tick raises it by one in BCD, and 99 wraps to 00 with a carry into seconds. Seconds and minutes count 00..59, and 59 wraps to 00 with a carry upward.
- R3: With hours bit 7 = 0 (24-hour), hours count 00..23 using bits 5..4 as the tens digit, and 23 wraps to 00 with a carry into the day and date.
- R4: With hours bit 7 = 1 (12-hour), bits 4..0 hold 01..12 and bit 5 is PM. 11 rolls to 12 and flips bit 5. 12 rolls to 01 with bit 5 unchanged. The day and date advance only when 11 PM rolls to 12 AM.
- R5: Day of week (register 4, bits 2..0) counts 1..7 and wraps 7 to 1 on each day carry, keeping bits 5 and 4.
- R6: Date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months, with a carry into the month.
- R7: February ends on 29 when the year value is divisible by 4 (00 included) and on 28 otherwise. Month 12 wraps to 01 with a carry into the year, and year 99 wraps to 00.
- R8: While register 4 bit 5 is 1, ticks change no register.
- R9: A commit replaces all eight live registers from the staging set in one cycle. A tick in the same cycle is dropped, and the next tick counts on from the loaded hundredths value.
- R10: Writes discard unused bits, which always read 0. The kept-bit masks per index 0..7 are FF, 7F, 7F, BF, 37, 3F, 1F, FF.
- R11: A snapshot captures all eight registers in the cycle of the strobe, taking the value from before any same-cycle tick. `rd_data_o` shows the captured byte chosen by `rd_idx_i`, and it holds until the next snapshot.
- R12: Without a tick, the live registers do not change. Each counted tick advances the time by exactly one hundredth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Single-cycle 100 Hz advance enable |
| stg_we_i | input | 1 | Write one byte into the staging set |
| stg_idx_i | input | 3 | Staging register index |
| stg_data_i | input | 8 | Staging byte |
| commit_i | input | 1 | Load the whole staging set into the live registers |
| snap_i | input | 1 | Capture the live registers for reading |
| rd_idx_i | input | 3 | Captured register index to read |
| rd_data_o | output | 8 | Captured byte at `rd_idx_i` |
| halted_o | output | 1 | Live halt bit (register 4 bit 5) |
| rstpin_ignore_o | output | 1 | Live reset-pin-ignore bit (register 4 bit 4) |

## Verification
The assertions take it that `tick_i` is a one-cycle pulse and that staging writes are not issued in the same cycle as a commit. They also take it that loaded time values are legal BCD within each field's range, since the roll-over checks only describe the wrap of a legal count. The stimulus drives every strobe for exactly one cycle away from the clock edge and keeps staging writes and commits in separate cycles. Every table vector is a legal calendar time. The only deliberately illegal bytes come from the all-ones mask load, and that load also sets the halt bit, so no roll-over check applies to those values.

// File: rtl/rtcb_pkg.sv
package rtcb_pkg;

    localparam int NUM_REGS = 8;
    localparam int REG_W    = 8;
    localparam int IDX_W    = $clog2(NUM_REGS);

    localparam int IX_HUND  = 0;
    localparam int IX_SEC   = 1;
    localparam int IX_MIN   = 2;
    localparam int IX_HOUR  = 3;
    localparam int IX_DOW   = 4;
    localparam int IX_DATE  = 5;
    localparam int IX_MONTH = 6;
    localparam int IX_YEAR  = 7;

    localparam int HR_MODE12_BIT = 7;
    localparam int HR_PM_BIT     = 5;
    localparam int DOW_HALT_BIT  = 5;
    localparam int DOW_RSTIG_BIT = 4;

    typedef logic [REG_W-1:0] regbyte_t;
    typedef logic [NUM_REGS-1:0][REG_W-1:0] regset_t;

    // Bits kept on write; the rest are dropped and read as zero.
    function automatic regbyte_t keep_mask(input int idx);
        case (idx)
            IX_SEC, IX_MIN: return 8'h7F;
            IX_HOUR:        return 8'hBF;
            IX_DOW:         return 8'h37;
            IX_DATE:        return 8'h3F;
            IX_MONTH:       return 8'h1F;
            default:        return 8'hFF;
        endcase
    endfunction

    // Power-on content: clock halted, reset pin ignored, 01/01 day 1.
    function automatic regbyte_t reset_value(input int idx);
        case (idx)
            IX_DOW:           return 8'h31;
            IX_DATE, IX_MONTH: return 8'h01;
            default:          return 8'h00;
        endcase
    endfunction

    function automatic regset_t reset_set();
        regset_t s;
        for (int i = 0; i < NUM_REGS; i++) begin
            s[i] = reset_value(i);
        end
        return s;
    endfunction

    function automatic logic [7:0] bcd_bin(input regbyte_t b);
        return ({4'h0, b[7:4]} * 8'd10) + {4'h0, b[3:0]};
    endfunction

    function automatic regbyte_t bcd_inc(input regbyte_t b);
        if (b[3:0] >= 4'd9) begin
            return {b[7:4] + 4'd1, 4'h0};
        end
        return {b[7:4], b[3:0] + 4'd1};
    endfunction

    // Last valid date (binary) for a BCD month and BCD year.
    function automatic logic [7:0] month_last(input regbyte_t mon, input regbyte_t yr);
        logic [7:0] m;
        logic [7:0] y;
        m = bcd_bin(mon);
        y = bcd_bin(yr);
        case (m)
            8'd2:                      return (y[1:0] == 2'b00) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:   return 8'd30;
            default:                   return 8'd31;
        endcase
    endfunction

    // Advance the hours byte by one; bit 8 of the result is the day carry.
    function automatic logic [8:0] hour_step(input regbyte_t hr);
        regbyte_t   nx;
        logic       carry;
        logic [7:0] val;
        nx    = hr;
        carry = 1'b0;
        if (hr[HR_MODE12_BIT]) begin
            val = bcd_bin({3'b000, hr[4:0]});
            if (val == 8'd11) begin
                nx[4:0]       = 5'h12;
                nx[HR_PM_BIT] = ~hr[HR_PM_BIT];
                carry         = hr[HR_PM_BIT];
            end else if (val >= 8'd12) begin
                nx[4:0] = 5'h01;
            end else if (hr[3:0] >= 4'd9) begin
                nx[4]   = 1'b1;
                nx[3:0] = 4'h0;
            end else begin
                nx[3:0] = hr[3:0] + 4'd1;
            end
        end else begin
            val = bcd_bin({2'b00, hr[5:0]});
            if (val >= 8'd23) begin
                nx[5:0] = 6'h00;
                carry   = 1'b1;
            end else if (hr[3:0] >= 4'd9) begin
                nx[5:4] = hr[5:4] + 2'd1;
                nx[3:0] = 4'h0;
            end else begin
                nx[3:0] = hr[3:0] + 4'd1;
            end
        end
        nx[6] = 1'b0;
        return {carry, nx};
    endfunction

endpackage

// File: rtl/rtc_stage.sv
module rtc_stage
    import rtcb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [IDX_W-1:0] idx_i,
    input  regbyte_t         data_i,
    output regset_t          stage_o
);

    typedef struct packed {
        regset_t bytes;
    } stage_state_t;

    stage_state_t st_d, st_q;
    logic [NUM_REGS-1:0] hit;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
        assign hit[g] = we_i && (idx_i == IDX_W'(g));
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (hit[i]) begin
                st_d.bytes[i] = data_i & keep_mask(i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.bytes <= reset_set();
        end else begin
            st_q <= st_d;
        end
    end

    assign stage_o = st_q.bytes;

endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
    import rtcb_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tick_i,
    input  logic    load_i,
    input  regset_t load_set_i,
    output regset_t live_o
);

    typedef struct packed {
        regset_t regs;
    } chain_state_t;

    chain_state_t st_d, st_q;

    logic       advance;
    logic       c_hund, c_sec, c_min, c_hour, c_date, c_month;
    logic [8:0] hr_next;
    logic [7:0] last_day;
    logic [2:0] dow_cur;

    always_comb begin
        st_d     = st_q;
        advance  = tick_i && !st_q.regs[IX_DOW][DOW_HALT_BIT];
        hr_next  = hour_step(st_q.regs[IX_HOUR]);
        last_day = month_last(st_q.regs[IX_MONTH], st_q.regs[IX_YEAR]);
        dow_cur  = st_q.regs[IX_DOW][2:0];

        c_hund  = bcd_bin(st_q.regs[IX_HUND]) >= 8'd99;
        c_sec   = c_hund && (bcd_bin(st_q.regs[IX_SEC]) >= 8'd59);
        c_min   = c_sec && (bcd_bin(st_q.regs[IX_MIN]) >= 8'd59);
        c_hour  = c_min && hr_next[8];
        c_date  = c_hour && (bcd_bin(st_q.regs[IX_DATE]) >= last_day);
        c_month = c_date && (bcd_bin(st_q.regs[IX_MONTH]) >= 8'd12);

        if (load_i) begin
            st_d.regs = load_set_i;
        end else if (advance) begin
            st_d.regs[IX_HUND] = c_hund ? 8'h00 : bcd_inc(st_q.regs[IX_HUND]);
            if (c_hund) begin
                st_d.regs[IX_SEC] = c_sec ? 8'h00 : bcd_inc(st_q.regs[IX_SEC]);
            end
            if (c_sec) begin
                st_d.regs[IX_MIN] = c_min ? 8'h00 : bcd_inc(st_q.regs[IX_MIN]);
            end
            if (c_min) begin
                st_d.regs[IX_HOUR] = hr_next[7:0];
            end
            if (c_hour) begin
                st_d.regs[IX_DOW][2:0] = (dow_cur >= 3'd7) ? 3'd1 : dow_cur + 3'd1;
                st_d.regs[IX_DATE]     = c_date ? 8'h01 : bcd_inc(st_q.regs[IX_DATE]);
            end
            if (c_date) begin
                st_d.regs[IX_MONTH] = c_month ? 8'h01 : bcd_inc(st_q.regs[IX_MONTH]);
            end
            if (c_month) begin
                st_d.regs[IX_YEAR] = (bcd_bin(st_q.regs[IX_YEAR]) >= 8'd99) ? 8'h00
                                                                             : bcd_inc(st_q.regs[IX_YEAR]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.regs <= reset_set();
        end else begin
            st_q <= st_d;
        end
    end

    assign live_o = st_q.regs;

endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot
    import rtcb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snap_i,
    input  regset_t          live_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output regset_t          snap_o,
    output regbyte_t         rd_data_o
);

    typedef struct packed {
        regset_t held;
    } snap_state_t;

    snap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (snap_i) begin
            st_d.held = live_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.held <= reset_set();
        end else begin
            st_q <= st_d;
        end
    end

    assign snap_o    = st_q.held;
    assign rd_data_o = st_q.held[rd_idx_i];

endmodule

// File: rtl/rtc_bcd_regfile.sv
module rtc_bcd_regfile
    import rtcb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             stg_we_i,
    input  logic [IDX_W-1:0] stg_idx_i,
    input  logic [REG_W-1:0] stg_data_i,
    input  logic             commit_i,
    input  logic             snap_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [REG_W-1:0] rd_data_o,
    output logic             halted_o,
    output logic             rstpin_ignore_o
);

    regset_t stage_set;
    regset_t live_set;
    regset_t snap_set;

    rtc_stage u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (stg_we_i),
        .idx_i   (stg_idx_i),
        .data_i  (stg_data_i),
        .stage_o (stage_set)
    );

    rtc_time_chain u_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .load_i     (commit_i),
        .load_set_i (stage_set),
        .live_o     (live_set)
    );

    rtc_snapshot u_snap (
        .clk       (clk),
        .rst_n     (rst_n),
        .snap_i    (snap_i),
        .live_i    (live_set),
        .rd_idx_i  (rd_idx_i),
        .snap_o    (snap_set),
        .rd_data_o (rd_data_o)
    );

    assign halted_o        = live_set[IX_DOW][DOW_HALT_BIT];
    assign rstpin_ignore_o = live_set[IX_DOW][DOW_RSTIG_BIT];

endmodule

// File: rtl/rtc_bcd_regfile_chk.sv
module rtc_bcd_regfile_chk
    import rtcb_pkg::*;
(
    input logic    clk,
    input logic    rst_n,
    input logic    tick_i,
    input logic    commit_i,
    input logic    snap_i,
    input regset_t stage_set,
    input regset_t live_set,
    input regset_t snap_set
);

    logic halted;
    assign halted = live_set[IX_DOW][DOW_HALT_BIT];

    // R9: a commit loads exactly the staged set
    assert_commit_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> (live_set == $past(stage_set)));

    // R12: no tick, no change
    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !commit_i) |=> $stable(live_set));

    // R8: halted clock ignores ticks
    assert_halt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !commit_i) |=> $stable(live_set));

    // R11: captured set only changes on a snapshot strobe
    assert_snap_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_i |=> $stable(snap_set));

    // R11: snapshot takes the pre-edge live value
    assert_snap_value_R11: assert property (@(posedge clk) disable iff (!rst_n)
        snap_i |=> (snap_set == $past(live_set)));

    // R2: hundredths wrap from 99 to 00
    assert_hund_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !commit_i && !halted && live_set[IX_HUND] == 8'h99)
        |=> (live_set[IX_HUND] == 8'h00));

    // R10: unused bits stay zero
    assert_zero_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (live_set[IX_SEC][7] == 1'b0) && (live_set[IX_MIN][7] == 1'b0) &&
        (live_set[IX_HOUR][6] == 1'b0) && (live_set[IX_DOW][7:6] == 2'b00) &&
        (live_set[IX_DOW][3] == 1'b0) && (live_set[IX_DATE][7:6] == 2'b00) &&
        (live_set[IX_MONTH][7:5] == 3'b000));

endmodule

bind rtc_bcd_regfile rtc_bcd_regfile_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .commit_i  (commit_i),
    .snap_i    (snap_i),
    .stage_set (stage_set),
    .live_set  (live_set),
    .snap_set  (snap_set)
);

// File: tb/rtc_bcd_regfile_tb.sv
module rtc_bcd_regfile_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       stg_we_i = 1'b0;
    logic [2:0] stg_idx_i = 3'd0;
    logic [7:0] stg_data_i = 8'h00;
    logic       commit_i = 1'b0;
    logic       snap_i = 1'b0;
    logic [2:0] rd_idx_i = 3'd0;
    logic [7:0] rd_data_o;
    logic       halted_o;
    logic       rstpin_ignore_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rtc_bcd_regfile u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .tick_i          (tick_i),
        .stg_we_i        (stg_we_i),
        .stg_idx_i       (stg_idx_i),
        .stg_data_i      (stg_data_i),
        .commit_i        (commit_i),
        .snap_i          (snap_i),
        .rd_idx_i        (rd_idx_i),
        .rd_data_o       (rd_data_o),
        .halted_o        (halted_o),
        .rstpin_ignore_o (rstpin_ignore_o)
    );

    // {before, after one tick}; bytes ordered r7..r0
    localparam int NV = 20;
    localparam logic [127:0] VECS [NV] = '{
        {64'h00010101_00000099, 64'h00010101_00000100},  // R2 hundredths carry
        {64'h00010101_10595999, 64'h00010101_11000000},  // R2 min carry
        {64'h24061503_23595999, 64'h24061604_00000000},  // R3 23 -> 00
        {64'h24061503_91595999, 64'h24061503_B2000000},  // R4 11AM -> 12PM
        {64'h24061503_B2595999, 64'h24061503_A1000000},  // R4 12PM -> 01PM
        {64'h24061503_B1595999, 64'h24061604_92000000},  // R4 11PM -> 12AM
        {64'h24031007_23595999, 64'h24031101_00000000},  // R5 day 7 -> 1
        {64'h24043002_23595999, 64'h24050103_00000000},  // R6 Apr 30
        {64'h25013102_23595999, 64'h25020103_00000000},  // R6 Jan 31
        {64'h25013002_23595999, 64'h25013103_00000000},  // R6 Jan 30 no wrap
        {64'h24022802_23595999, 64'h24022903_00000000},  // R7 leap 28
        {64'h24022902_23595999, 64'h24030103_00000000},  // R7 leap 29
        {64'h23022802_23595999, 64'h23030103_00000000},  // R7 common 28
        {64'h00022802_23595999, 64'h00022903_00000000},  // R7 year 00 leap
        {64'h99123105_23595999, 64'h00010106_00000000},  // R7 year wrap
        {64'h23113002_23595999, 64'h23120103_00000000},  // R6 Nov 30
        {64'h10022802_23595999, 64'h10030103_00000000},  // R7 year 10
        {64'h12022802_23595999, 64'h12022903_00000000},  // R7 year 12
        {64'h00010101_09595999, 64'h00010101_10000000},  // R3 09 -> 10
        {64'h00010101_89595999, 64'h00010101_90000000}   // R4 09AM -> 10AM
    };
    localparam int VREQ [NV] = '{2, 2, 3, 4, 4, 4, 5, 6, 6, 6, 7, 7, 7, 7, 7, 6, 7, 7, 3, 4};

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic stage_all(input logic [63:0] v);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            stg_we_i   = 1'b1;
            stg_idx_i  = 3'(i);
            stg_data_i = v[8*i +: 8];
        end
        @(negedge clk);
        stg_we_i = 1'b0;
    endtask

    task automatic do_commit(input bit with_tick);
        @(negedge clk);
        commit_i = 1'b1;
        tick_i   = with_tick;
        @(negedge clk);
        commit_i = 1'b0;
        tick_i   = 1'b0;
    endtask

    task automatic do_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_i = 1'b1;
            @(negedge clk);
            tick_i = 1'b0;
        end
    endtask

    task automatic do_snap(input bit with_tick);
        @(negedge clk);
        snap_i = 1'b1;
        tick_i = with_tick;
        @(negedge clk);
        snap_i = 1'b0;
        tick_i = 1'b0;
    endtask

    task automatic read_all(output logic [63:0] v);
        for (int i = 0; i < 8; i++) begin
            rd_idx_i = 3'(i);
            #1;
            v[8*i +: 8] = rd_data_o;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents and control outputs
        @(negedge clk);
        read_all(rv);
        check("R1", rv, 64'h00010131_00000000);
        check("R1", {62'd0, halted_o, rstpin_ignore_o}, 64'd3);

        // R8: halted after reset, ticks ignored
        do_ticks(3);
        do_snap(1'b0);
        read_all(rv);
        check("R8", rv, 64'h00010131_00000000);

        // Table of roll-over vectors
        for (int v = 0; v < NV; v++) begin
            stage_all(VECS[v][127:64]);
            do_commit(1'b0);
            do_ticks(1);
            do_snap(1'b0);
            read_all(rv);
            check($sformatf("R%0d vec%0d", VREQ[v], v), rv, VECS[v][63:0]);
        end

        // R10: unused bits dropped; bit 5 of reg 4 set so clock halts
        stage_all(64'hFFFFFFFF_FFFFFFFF);
        do_commit(1'b0);
        do_snap(1'b0);
        read_all(rv);
        check("R10", rv, 64'hFF1F3F37_BF7F7FFF);
        check("R10", {63'd0, halted_o}, 64'd1);
        do_ticks(3);
        do_snap(1'b0);
        read_all(rv);
        check("R8", rv, 64'hFF1F3F37_BF7F7FFF);

        // R9: commit with simultaneous tick drops the tick
        stage_all(64'h00010101_12000050);
        do_commit(1'b1);
        do_snap(1'b0);
        read_all(rv);
        check("R9", rv, 64'h00010101_12000050);
        do_ticks(1);
        do_snap(1'b0);
        read_all(rv);
        check("R9", rv, 64'h00010101_12000051);

        // R12: five ticks, then idle cycles
        do_ticks(5);
        repeat (10) @(negedge clk);
        do_snap(1'b0);
        read_all(rv);
        check("R12", rv, 64'h00010101_12000056);

        // R11: captured value holds across ticks until next snapshot
        do_ticks(3);
        read_all(rv);
        check("R11", rv, 64'h00010101_12000056);
        do_snap(1'b1);
        read_all(rv);
        check("R11", rv, 64'h00010101_12000059);
        do_snap(1'b0);
        read_all(rv);
        check("R11", rv, 64'h00010101_12000060);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule